// File: doc/BRIEF.md
# Nonvolatile Write Cycle Controller

This block sits between the serial protocol engine of a small byte-wide nonvolatile memory and its storage array. It owns the timed programming cycle that follows a write transfer. While a write transfer runs, the protocol engine hands over the word address byte and then each acknowledged data byte. The block gathers these into a one-page staging buffer. The next address location wraps within the current page, so that a long burst overwrites its own earlier bytes.

A STOP that arrives after at least one data byte was taken starts a fixed-length busy period, counted in system clocks. During the first page-size cycles of that period, the staged bytes are written into the array one per clock. Only the positions that the transfer actually filled are written. While busy, every strobe from the engine is ignored. A matching device address also gets no acknowledge, so the bus master can poll with START plus address until it sees an ACK. A STOP with no data byte, or a repeated START before STOP, discards the staged data and starts nothing.

`MEM_BYTES` sets the array size. The page is 8 bytes for a 256-byte array and 16 bytes for anything larger. `CYCLE_CLKS` sets the busy length and must be at least the page size.

Top module: `nvm_write_cycle`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and no array write occurs until a write transfer has been completed.
- R2: A `stop_evt` accepted while idle, after at least one accepted `data_stb` since the last `addr_stb` or `start_evt`, raises `busy` on the next clock, and `busy` stays high for exactly `CYCLE_CLKS` cycles.
- R3: A `stop_evt` with no accepted data byte since the last `addr_stb` raises neither `busy` nor `mem_we`.
- R4: `addr_ack` equals `dev_match` in the same cycle while idle and is 0 whenever `busy` is high, whatever the read/write direction of the polling access.
- R5: While `busy` is high, `addr_stb`, `data_stb`, `start_evt` and `stop_evt` have no effect: the array contents, the busy length and the state after busy are the same as if they had not occurred.
- R6: The page is 16 bytes when `MEM_BYTES` exceeds 256 (8 bytes at 256). A data byte goes to the page holding the loaded word address. Its offset is the loaded address's low page bits plus the number of earlier data bytes, modulo the page size.
- R7: When more data bytes than the page size are sent, each later byte replaces the byte at the same wrapped offset, and the last value per offset is committed.
- R8: Only offsets written during the transfer are written to the array; the other bytes in that page keep their earlier contents, and the number of array writes equals the number of distinct offsets filled.
- R9: `mem_we` is only high while `busy` is high, and all writes of one commit address the same page.
- R10: A `start_evt` between the data bytes and `stop_evt` discards the staged bytes, so the following `stop_evt` starts no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_evt | input | 1 | One-cycle pulse: STOP seen on the bus |
| dev_match | input | 1 | One-cycle pulse: received device address matches this device |
| addr_ack | output | 1 | Acknowledge permission for the current device-address match |
| addr_stb | input | 1 | One-cycle pulse: word address byte received |
| addr_in | input | AW | Word address loaded by `addr_stb` |
| data_stb | input | 1 | One-cycle pulse: write data byte received and acknowledged |
| data_in | input | 8 | Data byte qualified by `data_stb` |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest situation to reach is traffic that arrives in the middle of a busy period: strobes, a STOP and a polling address match. Their effects show up only after busy ends, as a changed busy length, extra array writes or a falsely armed buffer. The stimulus counts clocks after the committing STOP and injects each event at a chosen busy cycle. It then measures the whole busy run, compares both the target page and the page named by the ignored address, and finishes with a lone STOP to prove that nothing was left armed. Page wrap and overflow are reached with bursts that start near the top of a page and run past the page size.

// File: rtl/nvm_wc_pkg.sv
package nvm_wc_pkg;

    // Page size rule: the smallest array uses 8-byte pages, larger ones 16.
    function automatic int page_bytes(input int mem_bytes);
        return (mem_bytes <= 256) ? 8 : 16;
    endfunction

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

endpackage

// File: rtl/nvm_wc_timer.sv
module nvm_wc_timer
    import nvm_wc_pkg::*;
#(
    parameter int CYCLE_CLKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        unique case (tmr_q.phase)
            PH_IDLE: begin
                if (go) begin
                    tmr_d.phase = PH_BUSY;
                    tmr_d.cnt   = CW'(CYCLE_CLKS - 1);
                end
            end
            PH_BUSY: begin
                if (tmr_q.cnt == '0) begin
                    tmr_d.phase = PH_IDLE;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - 1'b1;
                end
            end
            default: tmr_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = (tmr_q.phase == PH_BUSY);

endmodule

// File: rtl/nvm_wc_pagebuf.sv
module nvm_wc_pagebuf #(
    parameter int AW   = 10,
    parameter int PAGE = 16,
    parameter int PW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          discard,
    input  logic          load_addr,
    input  logic [AW-1:0] addr_in,
    input  logic          put_byte,
    input  logic [7:0]    byte_in,
    input  logic          commit_go,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);
    localparam int RW = AW - PW;

    typedef struct packed {
        logic [PAGE-1:0][7:0] bytes;
        logic [PAGE-1:0]      filled;
        logic [RW-1:0]        row;
        logic [PW-1:0]        ptr;
        logic                 draining;
        logic [PW-1:0]        cidx;
    } pbuf_t;

    pbuf_t pb_d, pb_q;
    logic [PAGE-1:0] slot_hit;

    // One-hot decode of the fill pointer, one comparator per slot.
    for (genvar s = 0; s < PAGE; s++) begin : g_slot
        assign slot_hit[s] = put_byte && (pb_q.ptr == PW'(s));
    end

    always_comb begin
        pb_d = pb_q;
        if (pb_q.draining) begin
            if (pb_q.cidx == PW'(PAGE - 1)) begin
                pb_d.draining = 1'b0;
                pb_d.filled   = '0;
                pb_d.cidx     = '0;
            end else begin
                pb_d.cidx = pb_q.cidx + 1'b1;
            end
        end else if (commit_go) begin
            pb_d.draining = 1'b1;
            pb_d.cidx     = '0;
        end else if (discard) begin
            pb_d.filled = '0;
        end else if (load_addr) begin
            pb_d.row    = addr_in[AW-1:PW];
            pb_d.ptr    = addr_in[PW-1:0];
            pb_d.filled = '0;
        end else if (put_byte) begin
            for (int s = 0; s < PAGE; s++) begin
                if (slot_hit[s]) begin
                    pb_d.bytes[s]  = byte_in;
                    pb_d.filled[s] = 1'b1;
                end
            end
            pb_d.ptr = pb_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign mem_we    = pb_q.draining && pb_q.filled[pb_q.cidx];
    assign mem_addr  = {pb_q.row, pb_q.cidx};
    assign mem_wdata = pb_q.bytes[pb_q.cidx];

endmodule

// File: rtl/nvm_write_cycle.sv
module nvm_write_cycle
    import nvm_wc_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int CYCLE_CLKS = 40,
    localparam int PAGE      = page_bytes(MEM_BYTES),
    localparam int AW        = $clog2(MEM_BYTES),
    localparam int PW        = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic          dev_match,
    output logic          addr_ack,
    input  logic          addr_stb,
    input  logic [AW-1:0] addr_in,
    input  logic          data_stb,
    input  logic [7:0]    data_in,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);
    typedef struct packed {
        logic armed;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic open_in;
    logic launch;

    assign open_in = !busy;
    assign launch  = open_in && stop_evt && ctl_q.armed;

    always_comb begin
        ctl_d = ctl_q;
        if (open_in) begin
            if (start_evt || addr_stb || stop_evt) begin
                ctl_d.armed = 1'b0;
            end else if (data_stb) begin
                ctl_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr_ack = dev_match && open_in;

    nvm_wc_timer #(
        .CYCLE_CLKS(CYCLE_CLKS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (launch),
        .busy (busy)
    );

    nvm_wc_pagebuf #(
        .AW  (AW),
        .PAGE(PAGE),
        .PW  (PW)
    ) u_pagebuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .discard  (open_in && start_evt),
        .load_addr(open_in && addr_stb),
        .addr_in  (addr_in),
        .put_byte (open_in && data_stb),
        .byte_in  (data_in),
        .commit_go(launch),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

endmodule

// File: rtl/nvm_wc_chk.sv
module nvm_wc_chk #(
    parameter int AW         = 10,
    parameter int PW         = 4,
    parameter int CYCLE_CLKS = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          dev_match,
    input logic          addr_ack,
    input logic          addr_stb,
    input logic          data_stb,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);
    int   run_q;
    logic seen_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 0;
            seen_data_q <= 1'b0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
            if (!busy) begin
                if (start_evt || addr_stb || stop_evt) seen_data_q <= 1'b0;
                else if (data_stb)                     seen_data_q <= 1'b1;
            end
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CYCLE_CLKS));

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R3
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && !seen_data_q) |=> !busy);

    // R4
    poll_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !addr_ack);

    // R4
    poll_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dev_match) |-> addr_ack);

    // R9
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R9
    same_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy)) |->
            (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])));

endmodule

bind nvm_write_cycle nvm_wc_chk #(
    .AW        (AW),
    .PW        (PW),
    .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .dev_match(dev_match),
    .addr_ack (addr_ack),
    .addr_stb (addr_stb),
    .data_stb (data_stb),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/nvm_write_cycle_test.sv
`timescale 1ns/1ps
module nvm_write_cycle_test;
    localparam int MEMB = 1024;
    localparam int CYC  = 40;
    localparam int PAGE = 16;
    localparam int AW   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 0, stop_evt = 0, dev_match = 0, addr_stb = 0, data_stb = 0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic addr_ack, busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    logic [7:0] arr [MEMB];
    logic [7:0] exp_arr [MEMB];

    always #4 clk = ~clk;

    nvm_write_cycle #(.MEM_BYTES(MEMB), .CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .dev_match(dev_match), .addr_ack(addr_ack), .addr_stb(addr_stb),
        .addr_in(addr_in), .data_stb(data_stb), .data_in(data_in), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            arr[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    typedef struct packed {
        logic [9:0] addr;
        logic [5:0] n;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{addr: 10'h000, n: 6'd1,  seed: 8'h11},
        '{addr: 10'h023, n: 6'd4,  seed: 8'h40},
        '{addr: 10'h0AC, n: 6'd8,  seed: 8'h80},
        '{addr: 10'h3F5, n: 6'd16, seed: 8'h2B},
        '{addr: 10'h150, n: 6'd20, seed: 8'h61},
        '{addr: 10'h023, n: 6'd2,  seed: 8'hC0}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        addr_in = a; pulse(addr_stb);
    endtask

    task automatic send_byte(input logic [7:0] d);
        data_in = d; pulse(data_stb);
    endtask

    // Counts negedges with busy high; call right after the STOP pulse.
    task automatic busy_len(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    function automatic int page_diff(input int base);
        int bad = 0;
        for (int j = 0; j < PAGE; j++)
            if (arr[base + j] !== exp_arr[base + j]) bad++;
        return bad;
    endfunction

    task automatic run_write(input vec_t v, input string req);
        int len, w0, base, nd;
        logic [PAGE-1:0] hit;
        hit  = '0;
        base = int'(v.addr) & ~(PAGE - 1);
        w0   = wr_cnt;
        pulse(start_evt);
        send_addr(v.addr);
        for (int i = 0; i < int'(v.n); i++) begin
            logic [7:0] d;
            int off;
            d   = v.seed + 8'(i * 3);
            off = (int'(v.addr) + i) % PAGE;
            exp_arr[base + off] = d;
            hit[off] = 1'b1;
            send_byte(d);
        end
        pulse(stop_evt);
        busy_len(len);
        check(len == CYC, {req, " R2 busy length"}, len, CYC);
        nd = $countones(hit);
        check(wr_cnt - w0 == nd, {req, " R8 write count"}, wr_cnt - w0, nd);
        check(page_diff(base) == 0, {req, " R6/R7/R8 page contents"}, page_diff(base), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int len, w0;
        for (int k = 0; k < MEMB; k++) begin
            arr[k] = 8'h00;
            exp_arr[k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(mem_we == 1'b0, "R1 mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && wr_cnt == 0, "R1 idle after reset", wr_cnt, 0);

        // Vector table: page writes, wrap, overflow, partial rewrite (R6 R7 R8)
        foreach (VECS[i]) run_write(VECS[i], $sformatf("vec%0d", i));

        // R3: STOP after only the word address
        w0 = wr_cnt;
        pulse(start_evt);
        send_addr(10'h040);
        pulse(stop_evt);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R3 no busy after address-only", busy, 0);
        check(wr_cnt == w0, "R3 no array write", wr_cnt - w0, 0);

        // R10: repeated START discards staged bytes
        pulse(start_evt);
        send_addr(10'h060);
        send_byte(8'h5A);
        pulse(start_evt);
        pulse(stop_evt);
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && wr_cnt == w0, "R10 staged bytes discarded", wr_cnt - w0, 0);
        check(page_diff(10'h060) == 0, "R10 page untouched", page_diff(10'h060), 0);

        // R4: acknowledge while idle
        dev_match = 1'b1; #1;
        check(addr_ack == 1'b1, "R4 ack when idle", addr_ack, 1);
        @(negedge clk); dev_match = 1'b0;

        // R5 and R4: traffic during busy
        w0 = wr_cnt;
        pulse(start_evt);
        send_addr(10'h200);
        exp_arr[10'h200] = 8'hA1;
        exp_arr[10'h201] = 8'hA2;
        send_byte(8'hA1);
        send_byte(8'hA2);
        pulse(stop_evt);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            case (len)
                2: begin addr_in = 10'h300; addr_stb = 1'b1; end
                3: begin addr_stb = 1'b0; data_in = 8'hEE; data_stb = 1'b1; end
                4: begin data_stb = 1'b0; start_evt = 1'b1; end
                5: begin start_evt = 1'b0; data_stb = 1'b1; end
                6: begin data_stb = 1'b0; stop_evt = 1'b1; end
                7: begin stop_evt = 1'b0; dev_match = 1'b1; end
                default: begin
                    addr_stb = 0; data_stb = 0; start_evt = 0; stop_evt = 0;
                end
            endcase
            #1;
            if (len == 7) check(addr_ack == 1'b0, "R4 no ack while busy", addr_ack, 0);
            @(negedge clk);
            dev_match = 1'b0;
        end
        addr_stb = 0; data_stb = 0; start_evt = 0; stop_evt = 0;
        check(len == CYC, "R5 busy length unaffected", len, CYC);
        check(wr_cnt - w0 == 2, "R5 write count", wr_cnt - w0, 2);
        check(page_diff(10'h200) == 0, "R5 target page", page_diff(10'h200), 0);
        check(page_diff(10'h300) == 0, "R5 ignored page untouched", page_diff(10'h300), 0);
        pulse(stop_evt);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R5 not armed by ignored strobes", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule